// File: doc/BRIEF.md
# Floating-Point Exception Status Recorder

This block sits behind a floating-point execution unit. When an operation finishes, the unit presents a 5-bit vector of IEEE exception flags with a one-cycle valid strobe. The same cycle also carries the live status word and the program-counter pair of the instruction. On the next clock edge the block registers three results:

- a new status word;
- a trap indication;
- the program-counter pair the pipeline should continue with.

A trap is taken when any raised flag is also enabled in the status word's trap-enable field. In that case the current-exception field reports exactly one flag, chosen by fixed priority. The accrued field is left alone, the IEEE trap-type marker bit is set, and the PC pair is held. Without a trap, the current field takes the raw flag vector and the accrued field collects it. PC then takes nPC and nPC moves forward by one instruction.

Flag positions inside each 5-bit field are: invalid = bit 4, overflow = bit 3, underflow = bit 2, divide-by-zero = bit 1, inexact = bit 0. Status word layout:

- trap-enable field: bits 27:23;
- accrued field: bits 9:5;
- current field: bits 4:0;
- IEEE trap-type marker: bit 14.

Top module: `fexc_recorder`

## Requirements
- R1: While reset is asserted, and after it until the first valid strobe, status_q, pc_q and npc_q read zero and trap_q is low.
- R2: For a strobed operation, trap_q is high in the following cycle exactly when (op_flags AND status_in[27:23]) is nonzero.
- R3: Without a trap, status_q[4:0] equals op_flags.
- R4: With a trap, status_q[4:0] holds a single bit: the highest-priority bit of (op_flags AND status_in[27:23]). Priority order is bit 4, bit 3, bit 2, bit 1, bit 0.
- R5: Without a trap, status_q[9:5] equals status_in[9:5] OR op_flags. With a trap, it equals status_in[9:5].
- R6: With a trap, status_q[14] is 1. Without a trap, it equals status_in[14].
- R7: Without a trap, pc_q takes npc_in and npc_q takes npc_in + 4. With a trap, pc_q takes pc_in and npc_q takes npc_in.
- R8: An operation with op_flags all zero gives status_q[4:0] = 0, no trap, and an advancing PC pair.
- R9: Every status bit outside 4:0, 9:5 and 14 is copied from status_in.
- R10: In a cycle without op_valid, status_q, pc_q and npc_q keep their values in the next cycle and trap_q is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | One-cycle strobe: an operation has finished |
| op_flags | input | 5 | Raised IEEE exception flags |
| status_in | input | STAT_W | Status word before the update |
| pc_in | input | ADDR_W | PC of the finishing instruction |
| npc_in | input | ADDR_W | Next PC of the finishing instruction |
| status_q | output | STAT_W | Updated status word |
| trap_q | output | 1 | High for one cycle when the operation traps |
| pc_q | output | ADDR_W | PC to continue with |
| npc_q | output | ADDR_W | Next PC to continue with |

## Verification
The hardest case to reach is a trap where several enabled flags are raised at once and the highest raised flag is not enabled. The priority choice must then skip to a lower bit. Uniform random status words rarely line this up, so directed cases set the enable field and the flags against each other explicitly. The random phase also draws the enable field from a small set of sparse masks so that partial overlaps occur often.

// File: rtl/fexc_pkg.sv
package fexc_pkg;
  localparam int FLAG_W       = 5;
  localparam int TEN_LSB      = 23;
  localparam int ACC_LSB      = 5;
  localparam int CUR_LSB      = 0;
  localparam int TRAP_KIND_BIT = 14;
  localparam int MIN_STAT_W   = TEN_LSB + FLAG_W;

  typedef logic [FLAG_W-1:0] flag_t;
endpackage

// File: rtl/fexc_prio_pick.sv
module fexc_prio_pick #(
  parameter int W = 5
) (
  input  logic [W-1:0] req,
  output logic [W-1:0] pick
);
  logic found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i] && !found) begin
        pick[i] = 1'b1;
        found   = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fexc_status_merge.sv
module fexc_status_merge
  import fexc_pkg::*;
#(
  parameter int STAT_W = 64
) (
  input  logic [STAT_W-1:0] stat_cur,
  input  flag_t             flags,
  output logic [STAT_W-1:0] stat_nxt,
  output logic              trap_hit
);
  flag_t enabled;
  flag_t chosen;
  flag_t cur_val;

  assign enabled  = flags & stat_cur[TEN_LSB +: FLAG_W];
  assign trap_hit = |enabled;

  fexc_prio_pick #(.W(FLAG_W)) u_pick (
    .req  (enabled),
    .pick (chosen)
  );

  assign cur_val = trap_hit ? chosen : flags;

  always_comb begin
    stat_nxt = stat_cur;
    stat_nxt[CUR_LSB +: FLAG_W] = cur_val;
    if (trap_hit) begin
      stat_nxt[TRAP_KIND_BIT] = 1'b1;
    end else begin
      stat_nxt[ACC_LSB +: FLAG_W] = stat_cur[ACC_LSB +: FLAG_W] | flags;
    end
  end
endmodule

// File: rtl/fexc_pc_step.sv
module fexc_pc_step #(
  parameter int ADDR_W = 64,
  parameter int STEP   = 4
) (
  input  logic [ADDR_W-1:0] pc_cur,
  input  logic [ADDR_W-1:0] npc_cur,
  input  logic              advance,
  output logic [ADDR_W-1:0] pc_nxt,
  output logic [ADDR_W-1:0] npc_nxt
);
  localparam logic [ADDR_W-1:0] STEP_V = ADDR_W'(STEP);

  always_comb begin
    if (advance) begin
      pc_nxt  = npc_cur;
      npc_nxt = npc_cur + STEP_V;
    end else begin
      pc_nxt  = pc_cur;
      npc_nxt = npc_cur;
    end
  end
endmodule

// File: rtl/fexc_recorder.sv
module fexc_recorder
  import fexc_pkg::*;
#(
  parameter int STAT_W  = 64,
  parameter int ADDR_W  = 64,
  parameter int PC_STEP = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [4:0]        op_flags,
  input  logic [STAT_W-1:0] status_in,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [ADDR_W-1:0] npc_in,
  output logic [STAT_W-1:0] status_q,
  output logic              trap_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [ADDR_W-1:0] npc_q
);
  logic [STAT_W-1:0] stat_nxt;
  logic              trap_hit;
  logic [ADDR_W-1:0] pc_nxt, npc_nxt;
  logic              trap_d;

  fexc_status_merge #(.STAT_W(STAT_W)) u_merge (
    .stat_cur (status_in),
    .flags    (op_flags),
    .stat_nxt (stat_nxt),
    .trap_hit (trap_hit)
  );

  fexc_pc_step #(.ADDR_W(ADDR_W), .STEP(PC_STEP)) u_step (
    .pc_cur  (pc_in),
    .npc_cur (npc_in),
    .advance (!trap_hit),
    .pc_nxt  (pc_nxt),
    .npc_nxt (npc_nxt)
  );

  assign trap_d = op_valid & trap_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      pc_q     <= '0;
      npc_q    <= '0;
    end else if (op_valid) begin
      status_q <= stat_nxt;
      pc_q     <= pc_nxt;
      npc_q    <= npc_nxt;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) trap_q <= 1'b0;
    else        trap_q <= trap_d;
  end

  // R2: the trap decision follows the enabled flags of the strobed operation
  a_r2_trap_decision: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (trap_q == $past(|(op_flags & status_in[TEN_LSB +: FLAG_W]))));

  // R4: a trap reports exactly one current flag
  a_r4_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> ($countones(status_q[CUR_LSB +: FLAG_W]) == 1));

  // R5: a trap leaves the accrued field alone
  a_r5_acc_kept: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (!trap_q || status_q[ACC_LSB +: FLAG_W] == $past(status_in[ACC_LSB +: FLAG_W])));

  // R6: a trap sets the trap-type marker
  a_r6_kind_mark: assert property (@(posedge clk) disable iff (!rst_n)
    trap_q |-> status_q[TRAP_KIND_BIT]);

  // R7: a retiring operation moves the PC pair forward
  a_r7_pc_advance: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid |=> (trap_q || (pc_q == $past(npc_in) && npc_q == $past(npc_in) + ADDR_W'(PC_STEP))));

  // R8: no raised flags leaves the current field clear and no trap
  a_r8_clean_op: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_flags == '0) |=> (status_q[CUR_LSB +: FLAG_W] == '0 && !trap_q));

  // R10: idle cycles hold state and raise no trap
  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> ($stable(status_q) && $stable(pc_q) && $stable(npc_q) && !trap_q));
endmodule

// File: tb/fexc_recorder_test.sv
module fexc_recorder_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        op_valid;
  logic [4:0]  op_flags;
  logic [63:0] status_in, pc_in, npc_in;
  logic [63:0] status_q, pc_q, npc_q;
  logic        trap_q;

  int tests = 0;
  int fails = 0;

  logic [63:0] e_stat, e_pc, e_npc;
  logic        e_trap;

  always #(CLK_PERIOD/2) clk = ~clk;

  fexc_recorder uut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_flags(op_flags),
    .status_in(status_in), .pc_in(pc_in), .npc_in(npc_in),
    .status_q(status_q), .trap_q(trap_q), .pc_q(pc_q), .npc_q(npc_q)
  );

  function automatic logic [4:0] top_flag(input logic [4:0] v);
    if (v[4])      return 5'b10000;
    else if (v[3]) return 5'b01000;
    else if (v[2]) return 5'b00100;
    else if (v[1]) return 5'b00010;
    else if (v[0]) return 5'b00001;
    else           return 5'b00000;
  endfunction

  function automatic logic model_trap(input logic [63:0] s, input logic [4:0] f);
    return (f & s[27:23]) != 5'b0;
  endfunction

  function automatic logic [63:0] model_stat(input logic [63:0] s, input logic [4:0] f);
    logic [63:0] r;
    r = s;
    if (model_trap(s, f)) begin
      r[4:0] = top_flag(f & s[27:23]);
      r[14]  = 1'b1;
    end else begin
      r[4:0] = f;
      r[9:5] = s[9:5] | f;
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic apply(input logic v, input logic [4:0] f, input logic [63:0] s,
                       input logic [63:0] p, input logic [63:0] np);
    op_valid  = v;
    op_flags  = f;
    status_in = s;
    pc_in     = p;
    npc_in    = np;
    if (v) begin
      e_trap = model_trap(s, f);
      e_stat = model_stat(s, f);
      e_pc   = e_trap ? p : np;
      e_npc  = e_trap ? np : np + 64'd4;
    end else begin
      e_trap = 1'b0;
    end
    @(negedge clk);
    // status covers R3 R4 R5 R6 R8 R9; idle hold is R10
    check(v ? "R3 R4 R5 R6 R9 status" : "R10 status", status_q, e_stat);
    check(v ? "R2 trap" : "R10 trap", {63'b0, trap_q}, {63'b0, e_trap});
    check(v ? "R7 pc" : "R10 pc", pc_q, e_pc);
    check(v ? "R7 npc" : "R10 npc", npc_q, e_npc);
  endtask

  function automatic logic [63:0] r64();
    return {$urandom(), $urandom()};
  endfunction

  function automatic logic [63:0] with_ten(input logic [63:0] s, input logic [4:0] t);
    logic [63:0] r;
    r = s;
    r[27:23] = t;
    return r;
  endfunction

  initial begin
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [63:0] s;
    void'($urandom(32'd1234));
    rst_n = 1'b0; op_valid = 1'b1; op_flags = 5'h1f;
    status_in = '1; pc_in = '1; npc_in = '1;
    repeat (2) @(negedge clk);
    // R1: reset state
    check("R1 status", status_q, 64'd0);
    check("R1 trap", {63'b0, trap_q}, 64'd0);
    check("R1 pc", pc_q, 64'd0);
    check("R1 npc", npc_q, 64'd0);
    op_valid = 1'b0;
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", status_q | pc_q | npc_q, 64'd0);
    e_stat = '0; e_pc = '0; e_npc = '0;

    // R8: no flags raised, current field clears, PC advances
    s = r64(); s[4:0] = 5'h1f;
    apply(1'b1, 5'b0, s, 64'h1000, 64'h1004);
    check("R8 cur clear", {59'b0, status_q[4:0]}, 64'd0);
    // R4: all flags raised and enabled -> invalid only
    s = with_ten(r64(), 5'h1f); s[14] = 1'b0;
    apply(1'b1, 5'h1f, s, 64'h2000, 64'h2004);
    check("R4 invalid wins", {59'b0, status_q[4:0]}, 64'h10);
    check("R6 marker", {63'b0, status_q[14]}, 64'd1);
    // R4: only inexact enabled, overflow also raised
    apply(1'b1, 5'b01001, with_ten(r64(), 5'b00001), 64'h3000, 64'h3004);
    check("R4 inexact only", {59'b0, status_q[4:0]}, 64'h01);
    // R4: top raised flag not enabled, pick skips down
    apply(1'b1, 5'b01110, with_ten(r64(), 5'b00110), 64'h4000, 64'h4004);
    check("R4 underflow picked", {59'b0, status_q[4:0]}, 64'h04);
    // R5 and R3: no enables, all flags accumulate
    s = with_ten(r64(), 5'b0); s[9:5] = 5'b0;
    apply(1'b1, 5'h1f, s, 64'h5000, 64'h5004);
    check("R5 accrue", {59'b0, status_q[9:5]}, 64'h1f);
    // R6: marker kept as given without a trap
    s = with_ten(r64(), 5'b10000); s[14] = 1'b1;
    apply(1'b1, 5'b01111, s, 64'h6000, 64'h6004);
    check("R6 kept", {63'b0, status_q[14]}, 64'd1);
    // R7: nPC wraps at the top of the address space
    apply(1'b1, 5'b0, r64() & ~(64'h1f << 23), 64'hffff_fff8, 64'hffff_ffff_ffff_fffc);
    check("R7 wrap", npc_q, 64'd0);
    // R10: idle cycles with changing inputs
    for (int i = 0; i < 4; i++) apply(1'b0, 5'($urandom()), r64(), r64(), r64());

    // random phase, R9 covered by random upper bits
    for (int i = 0; i < 400; i++) begin
      logic [4:0] t;
      case ($urandom() % 6)
        0: t = 5'b0;
        1: t = 5'b00001;
        2: t = 5'b10000;
        3: t = 5'b00110;
        4: t = 5'h1f;
        default: t = 5'($urandom());
      endcase
      if ($urandom() % 5 == 0)
        apply(1'b0, 5'($urandom()), r64(), r64(), r64());
      else
        apply(1'b1, 5'($urandom()), with_ten(r64(), t), r64(), r64());
    end

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule